// File: doc/BRIEF.md
# Schedule-Aware Placement Cost Evaluator

This block scores one candidate placement of a dataflow graph onto a grid of processing elements that is time-multiplexed over several contexts. A placement engine streams the graph's edges into it, one edge per accepted beat. Each beat carries the grid position of the producing and consuming operation and the number of clock cycles that the schedule puts between them. Each position is a column, a row and a context index.

The block measures how far apart the two ends of an edge sit. This distance adds the gaps along all three axes, and the context gap counts like a spatial gap. The distance is compared with the scheduled cycle gap. A mismatch in either direction is charged, and the charge is weighted by the cycle gap, so that long-latency edges placed at the wrong distance cost more. The charges are summed over the edges of one evaluation into a saturating total.

When the last edge has been added, the schedule total is mixed with an externally computed bounding-box wirelength figure under a programmable 8-bit weight. The mixed figure is handed back with a one-cycle done strobe. A `start` pulse opens an evaluation and the `edge_last` flag closes it.

Top module: `sched_cost_eval`

## Requirements
- R1: The distance of an edge is |src_x−dst_x| + |src_y−dst_y| + |src_ctx−dst_ctx|, with every coordinate a 4-bit unsigned value. A gap in the context index adds to the distance exactly as a spatial gap does.
- R2: The charge for one edge is |distance − cycles| × cycles, with cycles a 6-bit unsigned value. The charge is nonzero both when the distance falls short of the cycle gap and when it overshoots it, as long as cycles is nonzero. The charge is exactly zero when the two are equal.
- R3: `sched_cost` presents the sum of the charges of every edge counted since the last `start`, and it holds that sum after the evaluation ends.
- R4: The sum is an ACC_W-bit unsigned value (32 by default). When an addition would exceed 2^ACC_W−1, the sum sticks at 2^ACC_W−1 and does not wrap.
- R5: `total_cost` = (alpha·wl_cost + (256−alpha)·sched_cost) >> 8, where alpha is an unsigned 8-bit fraction of 256. The discarded low bits are truncated toward zero.
- R6: `done` is high for exactly one cycle, two rising edges after the edge that accepts the beat flagged `edge_last`. `alpha` and `wl_cost` are taken on that accepting edge. `total_cost` holds its value until the next `done`.
- R7: A `start` pulse clears the sum. Beats accepted while no evaluation is open, and a beat accepted in the same cycle as `start`, add nothing and produce no `done`.
- R8: `edge_ready` is low from the cycle after the closing beat is accepted until `done` is raised. While it is low, no beat is taken and a `start` pulse is ignored.
- R9: After reset, `done` is 0, `total_cost` is 0, `sched_cost` is 0 and `edge_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Opens an evaluation and clears the sum |
| alpha | input | 8 | Wirelength weight in 1/256 steps |
| wl_cost | input | ACC_W | Precomputed wirelength figure |
| edge_valid | input | 1 | An edge beat is offered |
| edge_ready | output | 1 | The block can take an edge beat |
| edge_last | input | 1 | The offered beat closes the evaluation |
| src_x | input | 4 | Producer column |
| src_y | input | 4 | Producer row |
| src_ctx | input | 4 | Producer context index |
| dst_x | input | 4 | Consumer column |
| dst_y | input | 4 | Consumer row |
| dst_ctx | input | 4 | Consumer context index |
| cycles | input | 6 | Scheduled cycle gap of the edge |
| done | output | 1 | One-cycle strobe: `total_cost` is fresh |
| total_cost | output | ACC_W | Mixed placement cost |
| sched_cost | output | ACC_W | Running schedule-aware sum |

## Verification
A charge reaches `sched_cost` one rising edge after its beat is accepted, and `done` with the mixed `total_cost` follows one edge after that. The bench drives and samples on falling edges. After each closing beat, it counts the rising edges until `done` appears and requires exactly two. When the closing beat was already taken before a blocked cycle, it requires exactly one. The sums and the mixed value are read in the `done` cycle. A strobe held high one cycle longer is caught on the next falling edge.

// File: rtl/sched_cost_pkg.sv
package sched_cost_pkg;

    localparam int COORD_W = 4;
    localparam int CYC_W   = 6;
    localparam int ALPHA_W = 8;
    localparam int DIST_W  = COORD_W + 2;
    localparam int DIFF_W  = (DIST_W > CYC_W) ? DIST_W : CYC_W;
    localparam int PEN_W   = DIFF_W + CYC_W;

    typedef logic [COORD_W-1:0] coord_t;
    typedef logic [CYC_W-1:0]   cyc_t;
    typedef logic [DIST_W-1:0]  dist_t;
    typedef logic [DIFF_W-1:0]  diff_t;
    typedef logic [PEN_W-1:0]   pen_t;
    typedef logic [ALPHA_W-1:0] alpha_t;

    typedef struct packed {
        coord_t x;
        coord_t y;
        coord_t ctx;
    } place_t;

    typedef struct packed {
        place_t src;
        place_t dst;
        cyc_t   cyc;
        logic   last;
    } edge_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } eval_state_e;

    function automatic coord_t axis_gap(coord_t a, coord_t b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

    function automatic dist_t manhattan3(place_t a, place_t b);
        dist_t s;
        s = dist_t'(axis_gap(a.x, b.x))
          + dist_t'(axis_gap(a.y, b.y))
          + dist_t'(axis_gap(a.ctx, b.ctx));
        return s;
    endfunction

    function automatic pen_t sched_penalty(dist_t d, cyc_t c);
        diff_t dd;
        diff_t cc;
        diff_t m;
        dd = diff_t'(d);
        cc = diff_t'(c);
        m  = (dd >= cc) ? (dd - cc) : (cc - dd);
        return pen_t'(m) * pen_t'(c);
    endfunction

endpackage

// File: rtl/sched_edge_penalty.sv
module sched_edge_penalty
    import sched_cost_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  in_valid,
    input  edge_t in_edge,
    output logic  pen_valid,
    output pen_t  pen,
    output logic  pen_last
);

    dist_t dist_c;
    pen_t  pen_c;

    always_comb begin
        dist_c = manhattan3(in_edge.src, in_edge.dst);
        pen_c  = sched_penalty(dist_c, in_edge.cyc);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            pen_valid <= 1'b0;
            pen_last  <= 1'b0;
            pen       <= '0;
        end else begin
            pen_valid <= in_valid;
            pen_last  <= in_valid && in_edge.last;
            if (in_valid) begin
                pen <= pen_c;
            end
        end
    end

    // R2: co-located ends give distance 0, so the charge is cycles squared
    a_r2_colocated_charge: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !flush && (in_edge.src == in_edge.dst))
        |=> (pen == (pen_t'($past(in_edge.cyc)) * pen_t'($past(in_edge.cyc)))));

    // R2: a zero cycle gap never costs anything
    a_r2_zero_gap_free: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !flush && (in_edge.cyc == '0)) |=> (pen == '0));

endmodule

// File: rtl/sched_sat_accum.sv
module sched_sat_accum
    import sched_cost_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             add_en,
    input  pen_t             add_val,
    output logic [ACC_W-1:0] acc
);

    localparam int SUM_W = ACC_W + 1;
    localparam int PAD_W = SUM_W - PEN_W;

    logic [SUM_W-1:0] sum_c;

    always_comb begin
        sum_c = {1'b0, acc} + {{PAD_W{1'b0}}, add_val};
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
        end else if (add_en) begin
            acc <= sum_c[ACC_W] ? {ACC_W{1'b1}} : sum_c[ACC_W-1:0];
        end
    end

    // R4: without a clear the sum never moves downward (no wrap)
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (acc >= $past(acc)));

    // R7: a clear empties the sum
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clear |=> (acc == '0));

endmodule

// File: rtl/sched_cost_blend.sv
module sched_cost_blend
    import sched_cost_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  alpha_t           alpha,
    input  logic [ACC_W-1:0] wl,
    input  logic [ACC_W-1:0] sched,
    output logic             done,
    output logic [ACC_W-1:0] total
);

    localparam int PW = ACC_W + ALPHA_W + 1;
    localparam logic [ALPHA_W:0] UNITY = {1'b1, {ALPHA_W{1'b0}}};

    logic [ALPHA_W:0] beta;
    logic [PW-1:0]    mix;

    always_comb begin
        beta = UNITY - {1'b0, alpha};
        mix  = (PW'(wl) * PW'(alpha)) + (PW'(sched) * PW'(beta));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            total <= '0;
        end else begin
            done <= fire;
            if (fire) begin
                total <= ACC_W'(mix >> ALPHA_W);
            end
        end
    end

    // R5: a weighted mean never exceeds the larger of its two terms
    a_r5_blend_bounded: assert property (@(posedge clk) disable iff (rst)
        fire |=> (total <= (($past(wl) > $past(sched)) ? $past(wl) : $past(sched))));

endmodule

// File: rtl/sched_cost_eval.sv
module sched_cost_eval
    import sched_cost_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [ALPHA_W-1:0] alpha,
    input  logic [ACC_W-1:0]   wl_cost,
    input  logic               edge_valid,
    output logic               edge_ready,
    input  logic               edge_last,
    input  logic [COORD_W-1:0] src_x,
    input  logic [COORD_W-1:0] src_y,
    input  logic [COORD_W-1:0] src_ctx,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic [COORD_W-1:0] dst_ctx,
    input  logic [CYC_W-1:0]   cycles,
    output logic               done,
    output logic [ACC_W-1:0]   total_cost,
    output logic [ACC_W-1:0]   sched_cost
);

    eval_state_e      state_q;
    edge_t            edge_in;
    logic             take;
    logic             open_start;
    logic             pen_valid;
    logic             pen_last;
    pen_t             pen;
    logic             fin_q;
    alpha_t           alpha_q;
    logic [ACC_W-1:0] wl_q;

    always_comb begin
        edge_in.src.x   = src_x;
        edge_in.src.y   = src_y;
        edge_in.src.ctx = src_ctx;
        edge_in.dst.x   = dst_x;
        edge_in.dst.y   = dst_y;
        edge_in.dst.ctx = dst_ctx;
        edge_in.cyc     = cycles;
        edge_in.last    = edge_last;
        edge_ready      = (state_q != ST_DRAIN);
        open_start      = start && (state_q != ST_DRAIN);
        take            = edge_valid && edge_ready && (state_q == ST_RUN) && !start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (start) state_q <= ST_RUN;
                ST_RUN:   if (!start && take && edge_last) state_q <= ST_DRAIN;
                ST_DRAIN: if (fin_q) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fin_q   <= 1'b0;
            alpha_q <= '0;
            wl_q    <= '0;
        end else begin
            fin_q <= pen_valid && pen_last;
            if (take && edge_last) begin
                alpha_q <= alpha;
                wl_q    <= wl_cost;
            end
        end
    end

    sched_edge_penalty u_pen (
        .clk       (clk),
        .rst       (rst),
        .flush     (open_start),
        .in_valid  (take),
        .in_edge   (edge_in),
        .pen_valid (pen_valid),
        .pen       (pen),
        .pen_last  (pen_last)
    );

    sched_sat_accum #(.ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clear   (open_start),
        .add_en  (pen_valid),
        .add_val (pen),
        .acc     (sched_cost)
    );

    sched_cost_blend #(.ACC_W(ACC_W)) u_blend (
        .clk   (clk),
        .rst   (rst),
        .fire  (fin_q),
        .alpha (alpha_q),
        .wl    (wl_q),
        .sched (sched_cost),
        .done  (done),
        .total (total_cost)
    );

    // R8: the closing beat blocks the stream on the following cycle
    a_r8_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (take && edge_last) |=> !edge_ready);

    // R6: the done strobe lasts a single cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: with no evaluation open and no start, the sum is frozen
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_IDLE) && !start) |=> (sched_cost == $past(sched_cost)));

endmodule

// File: tb/tb_sched_cost_eval.sv
module tb_sched_cost_eval;
    import sched_cost_pkg::*;

    localparam int SAT_W = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  alpha = '0;
    logic [31:0] wl_cost = '0;
    logic        edge_valid = 1'b0;
    logic        edge_last = 1'b0;
    logic [3:0]  src_x = '0, src_y = '0, src_ctx = '0;
    logic [3:0]  dst_x = '0, dst_y = '0, dst_ctx = '0;
    logic [5:0]  cycles = '0;
    logic        edge_ready, done, s_ready, s_done;
    logic [31:0] total_cost, sched_cost;
    logic [SAT_W-1:0] s_total, s_sched;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    sched_cost_eval dut (
        .clk(clk), .rst(rst), .start(start), .alpha(alpha), .wl_cost(wl_cost),
        .edge_valid(edge_valid), .edge_ready(edge_ready), .edge_last(edge_last),
        .src_x(src_x), .src_y(src_y), .src_ctx(src_ctx),
        .dst_x(dst_x), .dst_y(dst_y), .dst_ctx(dst_ctx), .cycles(cycles),
        .done(done), .total_cost(total_cost), .sched_cost(sched_cost)
    );

    sched_cost_eval #(.ACC_W(SAT_W)) dut_sat (
        .clk(clk), .rst(rst), .start(start), .alpha(alpha), .wl_cost(wl_cost[SAT_W-1:0]),
        .edge_valid(edge_valid), .edge_ready(s_ready), .edge_last(edge_last),
        .src_x(src_x), .src_y(src_y), .src_ctx(src_ctx),
        .dst_x(dst_x), .dst_y(dst_y), .dst_ctx(dst_ctx), .cycles(cycles),
        .done(s_done), .total_cost(s_total), .sched_cost(s_sched)
    );

    // sx, sy, sctx, dx, dy, dctx, cycles, expected charge
    localparam int NV = 8;
    localparam int VEC [NV][8] = '{
        '{0, 0, 0, 2, 0, 0, 2, 0},
        '{1, 1, 0, 2, 1, 0, 2, 2},
        '{0, 0, 0, 3, 2, 1, 2, 8},
        '{5, 5, 1, 2, 7, 0, 4, 8},
        '{15, 15, 15, 0, 0, 0, 63, 1134},
        '{3, 3, 3, 3, 3, 3, 0, 0},
        '{0, 0, 0, 0, 0, 0, 63, 3969},
        '{7, 2, 0, 1, 2, 3, 5, 20}
    };

    function automatic longint blend_ref(longint a, longint w, longint s);
        return (a * w + (256 - a) * s) >>> 8;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
    endtask

    task automatic set_edge(input int i, input bit last);
        src_x = 4'(VEC[i][0]); src_y = 4'(VEC[i][1]); src_ctx = 4'(VEC[i][2]);
        dst_x = 4'(VEC[i][3]); dst_y = 4'(VEC[i][4]); dst_ctx = 4'(VEC[i][5]);
        cycles = 6'(VEC[i][6]);
        edge_last = last;
        edge_valid = 1'b1;
    endtask

    task automatic drive_edge(input int i, input bit last);
        set_edge(i, last);
        @(posedge clk); @(negedge clk);
        edge_valid = 1'b0;
        edge_last = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat < 8) begin
            @(posedge clk); @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int lat;
        bit seen;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        check(done == 1'b0, "R9 done", done, 0);
        check(total_cost == 0, "R9 total", total_cost, 0);
        check(sched_cost == 0, "R9 sched", sched_cost, 0);
        check(edge_ready == 1'b1, "R9 ready", edge_ready, 1);

        // R7 beat with no open evaluation
        drive_edge(6, 1'b1);
        seen = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (done) seen = 1'b1;
            @(posedge clk); @(negedge clk);
        end
        check(!seen, "R7 no done when idle", seen, 0);
        check(sched_cost == 0, "R7 idle beat ignored", sched_cost, 0);

        // R1 R2 R5 R6 single-edge evaluations from the table
        for (int i = 0; i < NV; i++) begin
            alpha = 8'(i * 32);
            wl_cost = 32'(1000 + i * 7);
            pulse_start();
            drive_edge(i, 1'b1);
            wait_done(lat);
            check(lat == 2, "R6 done latency", lat, 2);
            check(sched_cost == 32'(VEC[i][7]), "R1/R2 edge charge", sched_cost, VEC[i][7]);
            check(longint'(total_cost) == blend_ref(i * 32, 1000 + i * 7, VEC[i][7]),
                  "R5 blend", total_cost, blend_ref(i * 32, 1000 + i * 7, VEC[i][7]));
            @(posedge clk); @(negedge clk);
            check(done == 1'b0, "R6 single pulse", done, 0);
        end

        // R3 R8 multi-edge sum, back to back
        alpha = 8'd64;
        wl_cost = 32'd5000;
        pulse_start();
        for (int i = 0; i < NV; i++) drive_edge(i, i == NV - 1);
        check(edge_ready == 1'b0, "R8 ready low after last", edge_ready, 0);
        wait_done(lat);
        check(lat == 2, "R6 latency multi", lat, 2);
        check(sched_cost == 32'd5141, "R3 sum", sched_cost, 5141);
        check(longint'(total_cost) == blend_ref(64, 5000, 5141), "R5 blend multi",
              total_cost, blend_ref(64, 5000, 5141));
        @(posedge clk); @(negedge clk);
        check(longint'(total_cost) == blend_ref(64, 5000, 5141), "R6 total held",
              total_cost, blend_ref(64, 5000, 5141));
        check(sched_cost == 32'd5141, "R3 sum held", sched_cost, 5141);

        // R8 start and beat offered while blocked are ignored; R6 alpha/wl latched
        alpha = 8'd128;
        wl_cost = 32'd1;
        pulse_start();
        drive_edge(1, 1'b1);
        alpha = 8'd0;
        wl_cost = 32'd999;
        start = 1'b1;
        set_edge(6, 1'b1);
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        edge_valid = 1'b0;
        edge_last = 1'b0;
        wait_done(lat);
        check(lat == 1, "R8 done not delayed", lat, 1);
        check(sched_cost == 32'd2, "R8 blocked beat ignored", sched_cost, 2);
        check(total_cost == 32'd1, "R5 truncation with latched alpha R6", total_cost, 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sched_cost == 32'd2, "R8 blocked start ignored", sched_cost, 2);

        // R7 start mid-stream clears; beat in start cycle ignored
        alpha = 8'd255;
        wl_cost = 32'd1000;
        pulse_start();
        drive_edge(6, 1'b0);
        start = 1'b1;
        set_edge(4, 1'b0);
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        edge_valid = 1'b0;
        drive_edge(7, 1'b1);
        wait_done(lat);
        check(sched_cost == 32'd20, "R7 restart clears", sched_cost, 20);
        check(longint'(total_cost) == blend_ref(255, 1000, 20), "R5 alpha 255",
              total_cost, blend_ref(255, 1000, 20));

        // R4 saturation on the narrow instance
        alpha = 8'd0;
        wl_cost = 32'd7;
        pulse_start();
        for (int k = 0; k < 5; k++) drive_edge(6, k == 4);
        wait_done(lat);
        check(s_sched == {SAT_W{1'b1}}, "R4 saturated sum", s_sched, 16383);
        check(s_total == {SAT_W{1'b1}}, "R4 saturated total", s_total, 16383);
        check(sched_cost == 32'd19845, "R4 wide sum unclipped", sched_cost, 19845);
        check(total_cost == 32'd19845, "R5 alpha 0", total_cost, 19845);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule